// File: doc/BRIEF.md
# Floating-Point Coprocessor Register Port

This block sits between a CPU's coprocessor get/set path and a floating-point arithmetic engine. It holds a 32-bit status word, a 32-bit low-word staging register and two accumulators that are always kept as 64-bit IEEE doubles. A 4-bit register number selects the target. Its upper three bits form an operation code and its lowest bit picks an accumulator. A mode bit in the status word decides whether software sees each accumulator as a 32-bit single or as the high word of a double. In the double view, the low word travels through the staging register.

Reads return data and condition codes in the same cycle, with no register in the path. Reads can also return the negated or absolute value of an accumulator without changing it. Writes with an arithmetic operation code send both operands to an external engine through a start/done handshake. The block holds the CPU stalled until the engine reports completion, and then writes the result back into the chosen accumulator.

Top module: `fpcop_regport`

## Requirements
- R1: The register number maps as follows: 0 is status, 1 is the low-word register, 2 and 3 load or read accumulators 0 and 1. Numbers 4 to 15 carry operation code regNum[3:1] and accumulator select regNum[0].
- R2: The status word resets to 0. It can be written and read back in full at all times, whatever the unit's state. Reads of status drive all four condition codes to 0.
- R3: The unit is active only when status bit 1 is 1 and status bits 10:8 equal 3'b001. While inactive, reads of registers 1 to 15 return 0, and writes to them change no state.
- R4: Status bit 12 selects the view. A 0 selects the 32-bit single view. A 1 selects the 64-bit view, in which an accumulator number reads or writes the high word.
- R5: A single-view write converts to double as follows. Exponent 0 stays 0, and 255 becomes 2047. Any other exponent gets 896 added. The 23 fraction bits land in double fraction bits 51:29, and the lower fraction bits are zero-filled. A single-view read applies the reverse mapping and truncates fraction bits 28:0. A double exponent of 1151 or more (other than 2047) reads as signed infinity, and one of 896 or less (other than 0) reads as signed zero.
- R6: In the double view, a high-word write takes its low 32 bits from the low-word register. A high-word read of registers 2 to 7 copies the result's low 32 bits into the low-word register.
- R7: Reading operation code 2 returns the negated accumulator, and reading operation code 3 returns it with the sign cleared. Neither read modifies the accumulator.
- R8: On accumulator reads (registers 2 to 7), N equals bit 31 of the returned word and V is 0. Z is 1 only when the returned word is 0 and, in the double view, the low 32 bits are also 0. C is 1 when the viewed exponent is all ones.
- R9: A write with operation code 2 to 7 raises opStart for exactly one cycle, on the cycle after it is accepted. opCode and opSel hold the operation and the accumulator. opA holds the accumulator as a double. For code 2 (integer convert), opB holds the integer: the sign-extended word in the single view, or {wrData, low word} in the double view. For all other codes, opB holds the operand converted to double.
- R10: stall rises together with opStart and stays high until the cycle after opDone is seen. The engine's opResult is written into the selected accumulator at that edge. Accesses presented while stall is high are ignored.
- R11: Reads of registers 8 to 15 return 0 and leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acc | input | 1 | Access request this cycle |
| wr | input | 1 | 1 = set (write), 0 = get (read) |
| regNum | input | 4 | Coprocessor register number |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data (combinational) |
| ccN | output | 1 | Negative flag |
| ccZ | output | 1 | Zero flag |
| ccV | output | 1 | Overflow flag (always 0) |
| ccC | output | 1 | Infinity/NaN flag |
| stall | output | 1 | Engine busy; CPU must hold |
| opStart | output | 1 | One-cycle start pulse to engine |
| opCode | output | 3 | Operation code of the running operation |
| opSel | output | 1 | Destination accumulator |
| opA | output | 64 | Accumulator operand as double |
| opB | output | 64 | Second operand (double or integer) |
| opDone | input | 1 | Engine completion |
| opResult | input | 64 | Engine result as double |

## Verification
A corrupted accumulator or low-word register stays hidden until the next read. That read then shows the error in the same cycle, because the read path has no register. A conversion fault shows up as a mismatch only after a write in one view is read back in the other, so the directed tests cross the two views on purpose. A broken busy flag shows up within one cycle: a missing or repeated opStart, a stall that falls early, or a write accepted during a stall that later reads back. An error in the write-back shows up at the first read after opDone.

// File: rtl/fpcop_pkg.sv
package fpcop_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_LOW  = 2'd2,
    RD_ACC  = 2'd3
  } rdKind_e;

  localparam logic [2:0] OP_LOAD = 3'd1;
  localparam logic [2:0] OP_NEG  = 3'd2;
  localparam logic [2:0] OP_ABS  = 3'd3;
  localparam logic [2:0] OP_INT  = 3'd2;

  typedef struct packed {
    logic     wrStatus;
    logic     wrLow;
    logic     wrAcc;
    logic     ldLow;
    logic     capture;
    logic     commit;
    logic     accSel;
    logic [2:0] op;
    rdKind_e  rdKind;
  } ctl_t;

  // single -> double: rebias exponent, zero-fill low fraction
  function automatic logic [63:0] sglToDbl(input logic [31:0] w);
    logic [10:0] e;
    if (w[30:23] == 8'd0)        e = 11'd0;
    else if (w[30:23] == 8'hFF)  e = 11'h7FF;
    else                         e = {3'b000, w[30:23]} + 11'd896;
    return {w[31], e, w[22:0], 29'd0};
  endfunction

  // double -> single: rebias, truncate, clamp out-of-range
  function automatic logic [31:0] dblToSgl(input logic [63:0] d);
    logic [10:0] e;
    logic [10:0] eb;
    e  = d[62:52];
    eb = e - 11'd896;
    if (e == 11'd0)            return {d[63], 8'd0, d[51:29]};
    else if (e == 11'h7FF)     return {d[63], 8'hFF, d[51:29]};
    else if (e >= 11'd1151)    return {d[63], 8'hFF, 23'd0};
    else if (e <= 11'd896)     return {d[63], 31'd0};
    else                       return {d[63], eb[7:0], d[51:29]};
  endfunction

endpackage

// File: rtl/fpcop_ctrl.sv
module fpcop_ctrl
  import fpcop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       acc,
  input  logic       wr,
  input  logic [3:0] regNum,
  input  logic       active,
  input  logic       longMode,
  input  logic       opDone,
  output ctl_t       ctl,
  output logic       stall,
  output logic       opStart,
  output logic [2:0] opCode,
  output logic       opSel
);

  logic       busy;
  logic       startQ;
  logic [2:0] pendOp;
  logic       pendSel;
  logic       go;
  logic [2:0] op;

  assign go = acc && !busy;
  assign op = regNum[3:1];

  always_comb begin
    ctl        = '0;
    ctl.rdKind = RD_NONE;
    ctl.op     = op;
    ctl.accSel = busy ? pendSel : regNum[0];
    ctl.commit = busy && opDone;
    if (go) begin
      if (regNum == 4'd0) begin
        if (wr) ctl.wrStatus = 1'b1;
        else    ctl.rdKind   = RD_STAT;
      end else if (active) begin
        if (wr) begin
          if (regNum == 4'd1)      ctl.wrLow   = 1'b1;
          else if (op == OP_LOAD)  ctl.wrAcc   = 1'b1;
          else                     ctl.capture = 1'b1;
        end else begin
          if (regNum == 4'd1) ctl.rdKind = RD_LOW;
          else if (op <= OP_ABS) begin
            ctl.rdKind = RD_ACC;
            ctl.ldLow  = longMode;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      startQ  <= 1'b0;
      pendOp  <= 3'd0;
      pendSel <= 1'b0;
    end else begin
      startQ <= ctl.capture;
      if (ctl.capture) begin
        busy    <= 1'b1;
        pendOp  <= op;
        pendSel <= regNum[0];
      end else if (ctl.commit) begin
        busy <= 1'b0;
      end
    end
  end

  assign stall   = busy;
  assign opStart = startQ;
  assign opCode  = pendOp;
  assign opSel   = pendSel;

  // R9: start is a single-cycle pulse
  a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    opStart |=> !opStart);
  // R10: start is always covered by stall
  a_r10_stall_with_start: assert property (@(posedge clk) disable iff (!rstN)
    opStart |-> stall);
  // R10: done releases the stall on the next cycle
  a_r10_release: assert property (@(posedge clk) disable iff (!rstN)
    (stall && opDone) |=> !stall);
  // R10: nothing accepted while stalled
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !(ctl.wrAcc || ctl.wrLow || ctl.wrStatus || ctl.capture));

endmodule

// File: rtl/fpcop_dp.sv
module fpcop_dp
  import fpcop_pkg::*;
#(
  parameter int          EN_BIT   = 1,
  parameter int          MODE_BIT = 12,
  parameter int          SEL_LSB  = 8,
  parameter int          SEL_W    = 3,
  parameter logic [2:0]  UNIT_ID  = 3'd1,
  parameter int          NUM_ACC  = 2
)(
  input  logic        clk,
  input  logic        rstN,
  input  ctl_t        ctl,
  input  logic [31:0] wrData,
  input  logic [63:0] opResult,
  output logic        active,
  output logic        longMode,
  output logic [31:0] rdData,
  output logic        ccN,
  output logic        ccZ,
  output logic        ccV,
  output logic        ccC,
  output logic [63:0] opA,
  output logic [63:0] opB
);

  localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

  logic [31:0] statusR;
  logic [31:0] lowR;
  logic [63:0] accR [NUM_ACC];
  logic [63:0] accV;
  logic [63:0] rdRes;
  logic [31:0] view;
  logic [63:0] wrDbl;
  logic [63:0] intOp;

  assign active   = statusR[EN_BIT] && (statusR[SEL_MSB:SEL_LSB] == UNIT_ID);
  assign longMode = statusR[MODE_BIT];

  assign wrDbl = longMode ? {wrData, lowR} : sglToDbl(wrData);
  assign intOp = longMode ? {wrData, lowR} : {{32{wrData[31]}}, wrData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusR <= '0;
      lowR    <= '0;
      opA     <= '0;
      opB     <= '0;
    end else begin
      if (ctl.wrStatus) statusR <= wrData;
      if (ctl.wrLow)    lowR    <= wrData;
      else if (ctl.ldLow) lowR  <= rdRes[31:0];
      if (ctl.capture) begin
        opA <= accV;
        opB <= (ctl.op == OP_INT) ? intOp : wrDbl;
      end
    end
  end

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rstN)
        accR[i] <= '0;
      else if ((ctl.wrAcc || ctl.commit) && (int'(ctl.accSel) == i))
        accR[i] <= ctl.commit ? opResult : wrDbl;
    end
  end

  assign accV = accR[ctl.accSel];

  always_comb begin
    unique case (ctl.op)
      OP_NEG:  rdRes = {~accV[63], accV[62:0]};
      OP_ABS:  rdRes = {1'b0, accV[62:0]};
      default: rdRes = accV;
    endcase
  end

  assign view = longMode ? rdRes[63:32] : dblToSgl(rdRes);

  always_comb begin
    rdData = '0;
    ccN    = 1'b0;
    ccZ    = 1'b0;
    ccC    = 1'b0;
    unique case (ctl.rdKind)
      RD_STAT: rdData = statusR;
      RD_LOW:  rdData = lowR;
      RD_ACC: begin
        rdData = view;
        ccN    = view[31];
        ccZ    = (view == 32'd0) && (!longMode || rdRes[31:0] == 32'd0);
        ccC    = longMode ? (rdRes[62:52] == 11'h7FF) : (view[30:23] == 8'hFF);
      end
      default: rdData = '0;
    endcase
  end

  assign ccV = 1'b0;

  // R6: a long accumulator read leaves its low word in the staging register
  a_r6_low_side_effect: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldLow |=> lowR == $past(rdRes[31:0]));
  // R10: engine result lands in the selected accumulator
  a_r10_commit: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> accR[$past(ctl.accSel)] == $past(opResult));
  // R7: negate/abs reads leave the accumulators alone
  a_r7_read_no_modify: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdKind == RD_ACC && !ctl.commit) |=> $stable(accR[0]) && $stable(accR[1]));

endmodule

// File: rtl/fpcop_regport.sv
module fpcop_regport
  import fpcop_pkg::*;
#(
  parameter int         EN_BIT   = 1,
  parameter int         MODE_BIT = 12,
  parameter int         SEL_LSB  = 8,
  parameter logic [2:0] UNIT_ID  = 3'd1
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        acc,
  input  logic        wr,
  input  logic [3:0]  regNum,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        ccN,
  output logic        ccZ,
  output logic        ccV,
  output logic        ccC,
  output logic        stall,
  output logic        opStart,
  output logic [2:0]  opCode,
  output logic        opSel,
  output logic [63:0] opA,
  output logic [63:0] opB,
  input  logic        opDone,
  input  logic [63:0] opResult
);

  ctl_t ctl;
  logic active;
  logic longMode;

  fpcop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .acc(acc), .wr(wr), .regNum(regNum),
    .active(active), .longMode(longMode), .opDone(opDone),
    .ctl(ctl), .stall(stall), .opStart(opStart), .opCode(opCode), .opSel(opSel)
  );

  fpcop_dp #(
    .EN_BIT(EN_BIT), .MODE_BIT(MODE_BIT), .SEL_LSB(SEL_LSB), .SEL_W(3),
    .UNIT_ID(UNIT_ID), .NUM_ACC(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .opResult(opResult),
    .active(active), .longMode(longMode), .rdData(rdData),
    .ccN(ccN), .ccZ(ccZ), .ccV(ccV), .ccC(ccC), .opA(opA), .opB(opB)
  );

  // R3: inactive unit returns zero on every register but status
  a_r3_inactive_zero: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !wr && !stall && !active && regNum != 4'd0) |-> rdData == 32'd0);
  // R8: overflow flag never set
  a_r8_v_clear: assert property (@(posedge clk) disable iff (!rstN)
    acc |-> !ccV);

endmodule

// File: tb/fpcop_regport_tb.sv
`timescale 1ns/100ps
module fpcop_regport_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        acc = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  regNum = 4'd0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] rdData;
  logic        ccN, ccZ, ccV, ccC;
  logic        stall, opStart, opSel;
  logic [2:0]  opCode;
  logic [63:0] opA, opB;
  logic        opDone = 1'b0;
  logic [63:0] opResult = 64'd0;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  fpcop_regport u_dut (
    .clk(clk), .rstN(rstN), .acc(acc), .wr(wr), .regNum(regNum), .wrData(wrData),
    .rdData(rdData), .ccN(ccN), .ccZ(ccZ), .ccV(ccV), .ccC(ccC),
    .stall(stall), .opStart(opStart), .opCode(opCode), .opSel(opSel),
    .opA(opA), .opB(opB), .opDone(opDone), .opResult(opResult)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doSet(input logic [3:0] r, input logic [31:0] d);
    @(negedge clk);
    acc = 1'b1; wr = 1'b1; regNum = r; wrData = d;
    @(posedge clk); #1;
    acc = 1'b0; wr = 1'b0;
  endtask

  // returns {ccN,ccZ,ccV,ccC} in cc
  task automatic doGet(input logic [3:0] r, output logic [31:0] d, output logic [3:0] cc);
    @(negedge clk);
    acc = 1'b1; wr = 1'b0; regNum = r;
    #1;
    d  = rdData;
    cc = {ccN, ccZ, ccV, ccC};
    @(posedge clk); #1;
    acc = 1'b0;
  endtask

  task automatic finishOp(input logic [63:0] res);
    @(negedge clk);
    opDone = 1'b1; opResult = res;
    @(posedge clk); #1;
    opDone = 1'b0;
    chk("R10 stall released after done", {63'd0, stall}, 64'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [3:0] cc;
    chk("R10 stall low after reset", {63'd0, stall}, 64'd0);
    doGet(4'd0, d, cc);
    chk("R2 status reset value", {32'd0, d}, 64'd0);
  endtask

  task automatic t_inactive();
    logic [31:0] d; logic [3:0] cc;
    doSet(4'd2, 32'h3F800000);
    doSet(4'd1, 32'hAAAA5555);
    doGet(4'd2, d, cc);
    chk("R3 inactive acc read zero", {32'd0, d}, 64'd0);
    doSet(4'd0, 32'h0000_0002);          // enabled, wrong select
    doGet(4'd1, d, cc);
    chk("R3 wrong select reads zero", {32'd0, d}, 64'd0);
    doSet(4'd0, 32'h0000_0102);          // active, short
    doGet(4'd2, d, cc);
    chk("R3 inactive write ignored (acc)", {32'd0, d}, 64'd0);
    doSet(4'd0, 32'h0000_1102);
    doGet(4'd1, d, cc);
    chk("R3 inactive write ignored (low)", {32'd0, d}, 64'd0);
  endtask

  task automatic t_status();
    logic [31:0] d; logic [3:0] cc;
    doSet(4'd0, 32'hF0F0_1102);
    doGet(4'd0, d, cc);
    chk("R2 status readback", {32'd0, d}, 64'h0000_0000_F0F0_1102);
    chk("R2 status read cc", {60'd0, cc}, 64'd0);
  endtask

  task automatic t_views();
    logic [31:0] d; logic [3:0] cc;
    doSet(4'd0, 32'h0000_0102);
    doSet(4'd2, 32'h3FC00000);           // 1.5 single
    doGet(4'd2, d, cc);
    chk("R5 short round trip", {32'd0, d}, 64'h3FC00000);
    doSet(4'd0, 32'h0000_1102);
    doSet(4'd1, 32'hDEADBEEF);
    doGet(4'd2, d, cc);
    chk("R4 long high word of 1.5", {32'd0, d}, 64'h3FF80000);
    doGet(4'd1, d, cc);
    chk("R5 zero-filled low fraction", {32'd0, d}, 64'd0);
  endtask

  task automatic t_long();
    logic [31:0] d; logic [3:0] cc;
    doSet(4'd0, 32'h0000_1102);
    doSet(4'd1, 32'h12345678);
    doSet(4'd3, 32'hC0090000);
    doSet(4'd1, 32'h0);
    doGet(4'd3, d, cc);
    chk("R6 long high read", {32'd0, d}, 64'hC0090000);
    chk("R8 negative cc", {60'd0, cc}, 64'h8);
    doGet(4'd1, d, cc);
    chk("R6 low loaded by high read", {32'd0, d}, 64'h12345678);
    doSet(4'd1, 32'h0);
    doGet(4'd5, d, cc);                  // negate acc1
    chk("R7 negate result", {32'd0, d}, 64'h40090000);
    chk("R8 cc after negate", {60'd0, cc}, 64'h0);
    doGet(4'd1, d, cc);
    chk("R7 negate loads low", {32'd0, d}, 64'h12345678);
    doGet(4'd7, d, cc);                  // abs acc1
    chk("R7 abs result", {32'd0, d}, 64'h40090000);
    doGet(4'd3, d, cc);
    chk("R7 accumulator unchanged", {32'd0, d}, 64'hC0090000);
  endtask

  task automatic t_cc();
    logic [31:0] d; logic [3:0] cc;
    doSet(4'd0, 32'h0000_1102);
    doSet(4'd1, 32'h1);
    doSet(4'd2, 32'h0);
    doGet(4'd2, d, cc);
    chk("R8 Z clear with nonzero low", {60'd0, cc}, 64'h0);
    doSet(4'd1, 32'h0);
    doSet(4'd2, 32'h0);
    doGet(4'd2, d, cc);
    chk("R8 Z set on zero", {60'd0, cc}, 64'h4);
    doSet(4'd0, 32'h0000_0102);
    doSet(4'd2, 32'h7F800000);
    doGet(4'd2, d, cc);
    chk("R8 C on short infinity", {28'd0, d, cc}, {28'd0, 32'h7F800000, 4'h1});
    doSet(4'd0, 32'h0000_1102);
    doGet(4'd2, d, cc);
    chk("R5 infinity widened, C set", {28'd0, d, cc}, {28'd0, 32'h7FF00000, 4'h1});
    doSet(4'd2, 32'h47F00000);
    doSet(4'd0, 32'h0000_0102);
    doGet(4'd2, d, cc);
    chk("R5 large exponent clamps to inf", {32'd0, d}, 64'h7F800000);
    doSet(4'd0, 32'h0000_1102);
    doSet(4'd2, 32'hB7000000);
    doSet(4'd0, 32'h0000_0102);
    doGet(4'd2, d, cc);
    chk("R5 small exponent flushes to zero", {32'd0, d}, 64'h80000000);
  endtask

  task automatic t_op();
    logic [31:0] d; logic [3:0] cc;
    doSet(4'd0, 32'h0000_0102);
    doSet(4'd3, 32'h40000000);           // acc1 = 2.0
    doSet(4'd9, 32'h3F800000);           // op 4, acc1, operand 1.0
    chk("R9 start pulse", {63'd0, opStart}, 64'd1);
    chk("R10 stall with start", {63'd0, stall}, 64'd1);
    chk("R9 opCode", {61'd0, opCode}, 64'd4);
    chk("R9 opSel", {63'd0, opSel}, 64'd1);
    chk("R9 opA", opA, 64'h4000000000000000);
    chk("R9 opB converted", opB, 64'h3FF0000000000000);
    doSet(4'd3, 32'h0);                  // ignored while stalled
    chk("R9 start single cycle", {63'd0, opStart}, 64'd0);
    chk("R10 stall held", {63'd0, stall}, 64'd1);
    finishOp(64'h4008000000000000);
    doGet(4'd3, d, cc);
    chk("R10 result written back", {32'd0, d}, 64'h40400000);
  endtask

  task automatic t_int();
    logic [31:0] d; logic [3:0] cc;
    doSet(4'd0, 32'h0000_1102);
    doSet(4'd1, 32'h5);
    doSet(4'd5, 32'hFFFFFFFF);
    chk("R9 long int operand", opB, 64'hFFFFFFFF00000005);
    chk("R9 int opCode", {61'd0, opCode}, 64'd2);
    finishOp(64'h0);
    doSet(4'd0, 32'h0000_0102);
    doSet(4'd4, 32'hFFFFFFFE);
    chk("R9 short int sign-extended", opB, 64'hFFFFFFFFFFFFFFFE);
    chk("R9 int sel acc0", {63'd0, opSel}, 64'd0);
    finishOp(64'h3FF0000000000000);
    doGet(4'd8, d, cc);
    chk("R11 read of op code 4 returns zero", {32'd0, d}, 64'd0);
    chk("R11 no stall from op read", {63'd0, stall}, 64'd0);
    doGet(4'd2, d, cc);
    chk("R1 acc0 holds engine result", {32'd0, d}, 64'h3F800000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_inactive();
    t_status();
    t_views();
    t_long();
    t_cc();
    t_op();
    t_int();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule